// File: doc/BRIEF.md
# Serial Management Bus PHY-Side Responder

This block is the device end of a two-wire serial management bus. The station drives a management clock and a data line. The block samples the data line on every rising edge of that clock and waits until the recent history of sampled bits shows a long run of ones followed by a start pattern. It then decodes the frame header: an access code, a device address and a register index. After two turnaround bits, it either captures sixteen bits into a register or sends sixteen register bits back.

The block holds a small bank of 16-bit registers. Each register has a fixed set of protected bits that bus writes cannot change. Two identity registers and a status register are fully protected. The block answers only to the device address presented on its `phy_addr` input.

It runs on one system clock. The management clock arrives already synchronised to that clock. Edges are found by comparing the clock with its value one cycle earlier. The data line is split into an input, an output and an output enable, and the pad combines them outside the block.

Top module: `mgmt_serial_slave`

## Requirements
- R1: Bits are sampled on the rising edges of `mdc`. The block leaves the idle (preamble) state only when the last 32 sampled bits are thirty ones, a zero and then a one (0xFFFFFFFD, newest bit in the LSB). A shorter run of ones is not accepted, and the frame that follows it has no effect.
- R2: After the start pattern, the frame carries, in this order and each MSB first: a 2-bit access code, a 5-bit device address, a 5-bit register index, 2 turnaround bits and 16 data bits. After the 16th data bit the block returns to the idle state.
- R3: Access code 2'b10 is a read and 2'b01 is a write. The codes 2'b00 and 2'b11 neither drive the line nor change any register.
- R4: A frame whose device address differs from `phy_addr` never asserts `mdio_oe` and changes no register.
- R5: In a matching read, each data bit is presented on `mdio_out` after a falling edge of `mdc`, most significant bit first. `mdio_out` changes only in the cycle after a falling edge.
- R6: `mdio_oe` is high from the first falling edge of the data phase of a matching read until the 16th data rising edge. It is low at every other time.
- R7: A matching write takes effect at the 16th data bit. The new register value is (old AND mask) OR (data AND NOT mask).
- R8: Register reset values and protection masks (index: reset/mask) are: 0: 0x1140/0x0000; 1: STATUS_VAL/0xFFFF; 2: ID_HI/0xFFFF; 3: ID_LO/0xFFFF; 4: 0x01E1/0x001F; indices 5 to NUM_REGS-1: 0x0000/0x0000. The defaults are STATUS_VAL=0x7949, ID_HI=0x0141, ID_LO=0x0CC2 and NUM_REGS=8.
- R9: A register index at or above NUM_REGS reads as 0x0000, and a write to it is dropped.
- R10: During and right after reset, `mdio_oe` and `mdio_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock, already synchronised to `clk` |
| mdio_in | input | 1 | Sampled value of the data line |
| phy_addr | input | 5 | Device address this block answers to |
| mdio_out | output | 1 | Data value driven onto the line during reads |
| mdio_oe | output | 1 | Output enable for the data line |

## Verification
The assertions check the following on every cycle:
- the output enable is only ever high in the data phase, and it drops only when the decoder goes back to idle;
- the output value changes only after a falling clock edge;
- a register write fires only in the last data bit and is followed by idle.

The register contents themselves can only be shown by the bench's frame sequences. The bench sweeps all 32 register indices, several write patterns applied through each protection mask, every device address, both unused access codes and a truncated preamble.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int OPC_BITS  = 2;
    localparam int ADDR_BITS = 5;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;
    localparam int HIST_BITS = 32;
    localparam int CNT_W     = $clog2(DATA_BITS + 1);

    localparam logic [HIST_BITS-1:0] START_PATTERN = 32'hFFFF_FFFD;
    localparam logic [OPC_BITS-1:0]  OP_READ       = 2'b10;
    localparam logic [OPC_BITS-1:0]  OP_WRITE      = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_DEV,
        ST_IDX,
        ST_TURN,
        ST_DATA
    } fsm_e;

    function automatic logic [DATA_BITS-1:0] reg_mask(input int idx);
        case (idx)
            1, 2, 3: reg_mask = 16'hFFFF;
            4:       reg_mask = 16'h001F;
            default: reg_mask = 16'h0000;
        endcase
    endfunction

    function automatic logic [DATA_BITS-1:0] reg_reset(
        input int                   idx,
        input logic [DATA_BITS-1:0] status_val,
        input logic [DATA_BITS-1:0] id_hi,
        input logic [DATA_BITS-1:0] id_lo
    );
        case (idx)
            0:       reg_reset = 16'h1140;
            1:       reg_reset = status_val;
            2:       reg_reset = id_hi;
            3:       reg_reset = id_lo;
            4:       reg_reset = 16'h01E1;
            default: reg_reset = 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/mgmt_mdc_edge.sv
module mgmt_mdc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = mdc;
        rise   = mdc & ~prev_q;
        fall   = ~mdc & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
    import mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_in,
    input  logic [ADDR_BITS-1:0] phy_addr,
    input  logic [DATA_BITS-1:0] rd_data,
    output logic [ADDR_BITS-1:0] reg_idx,
    output logic                 wr_en,
    output logic [DATA_BITS-1:0] wr_data,
    output logic                 mdio_out,
    output logic                 mdio_oe,
    output fsm_e                 state
);
    typedef struct packed {
        fsm_e                 state;
        logic [CNT_W-1:0]     cnt;
        logic [HIST_BITS-1:0] shift;
        logic [OPC_BITS-1:0]  opc;
        logic [ADDR_BITS-1:0] dev;
        logic [ADDR_BITS-1:0] idx;
        logic                 hit;
        logic                 dout;
        logic                 oe;
    } fsm_t;

    localparam logic [CNT_W-1:0] N_OPC  = CNT_W'(OPC_BITS);
    localparam logic [CNT_W-1:0] N_ADDR = CNT_W'(ADDR_BITS);
    localparam logic [CNT_W-1:0] N_TA   = CNT_W'(TA_BITS);
    localparam logic [CNT_W-1:0] N_DATA = CNT_W'(DATA_BITS);

    fsm_t q, d;
    logic [HIST_BITS-1:0] shifted;
    logic [CNT_W-1:0]     cnt_inc;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        shifted = {q.shift[HIST_BITS-2:0], mdio_in};
        cnt_inc = q.cnt + 1'b1;
        wr_data = shifted[DATA_BITS-1:0];
        if (rise) begin
            d.shift = shifted;
            d.cnt   = cnt_inc;
            case (q.state)
                ST_IDLE: begin
                    if (shifted == START_PATTERN) begin
                        d.state = ST_OPC;
                        d.cnt   = '0;
                        d.shift = '0;
                    end
                end
                ST_OPC: begin
                    if (cnt_inc == N_OPC) begin
                        d.opc   = shifted[OPC_BITS-1:0];
                        d.state = ST_DEV;
                        d.cnt   = '0;
                        d.shift = '0;
                    end
                end
                ST_DEV: begin
                    if (cnt_inc == N_ADDR) begin
                        d.dev   = shifted[ADDR_BITS-1:0];
                        d.state = ST_IDX;
                        d.cnt   = '0;
                        d.shift = '0;
                    end
                end
                ST_IDX: begin
                    if (cnt_inc == N_ADDR) begin
                        d.idx   = shifted[ADDR_BITS-1:0];
                        d.hit   = (q.dev == phy_addr);
                        d.state = ST_TURN;
                        d.cnt   = '0;
                        d.shift = '0;
                    end
                end
                ST_TURN: begin
                    if (cnt_inc == N_TA) begin
                        d.state = ST_DATA;
                        d.cnt   = '0;
                        d.shift = '0;
                        if (q.opc == OP_READ && q.hit)
                            d.shift = {{(HIST_BITS-DATA_BITS){1'b0}}, rd_data};
                    end
                end
                ST_DATA: begin
                    if (cnt_inc == N_DATA) begin
                        d.state = ST_IDLE;
                        d.cnt   = '0;
                        d.shift = '0;
                        d.oe    = 1'b0;
                        wr_en   = (q.opc == OP_WRITE) && q.hit;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end else if (fall) begin
            if (q.state == ST_DATA && q.opc == OP_READ && q.hit) begin
                d.dout = q.shift[DATA_BITS-1];
                d.oe   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.cnt   <= '0;
            q.shift <= '0;
            q.opc   <= '0;
            q.dev   <= '0;
            q.idx   <= '0;
            q.hit   <= 1'b0;
            q.dout  <= 1'b0;
            q.oe    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign reg_idx  = q.idx;
    assign mdio_out = q.dout;
    assign mdio_oe  = q.oe;
    assign state    = q.state;
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank
    import mgmt_pkg::*;
#(
    parameter int                   NUM_REGS   = 8,
    parameter logic [DATA_BITS-1:0] STATUS_VAL = 16'h7949,
    parameter logic [DATA_BITS-1:0] ID_HI      = 16'h0141,
    parameter logic [DATA_BITS-1:0] ID_LO      = 16'h0CC2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_BITS-1:0] idx,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    output logic [DATA_BITS-1:0] rd_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DATA_BITS-1:0] regs_d [NUM_REGS];
    logic [DATA_BITS-1:0] regs_q [NUM_REGS];
    logic                 in_range;

    always_comb begin
        in_range = (int'(idx) < NUM_REGS);
        rd_data  = in_range ? regs_q[idx[IDX_W-1:0]] : '0;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [DATA_BITS-1:0] MASK = reg_mask(g);
        localparam logic [DATA_BITS-1:0] RSTV = reg_reset(g, STATUS_VAL, ID_HI, ID_LO);

        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && idx == ADDR_BITS'(g))
                regs_d[g] = (regs_q[g] & MASK) | (wr_data & ~MASK);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= RSTV;
            else        regs_q[g] <= regs_d[g];
        end
    end
endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave
    import mgmt_pkg::*;
#(
    parameter int          NUM_REGS   = 8,
    parameter logic [15:0] STATUS_VAL = 16'h7949,
    parameter logic [15:0] ID_HI      = 16'h0141,
    parameter logic [15:0] ID_LO      = 16'h0CC2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mdc,
    input  logic       mdio_in,
    input  logic [4:0] phy_addr,
    output logic       mdio_out,
    output logic       mdio_oe
);
    logic                 rise, fall;
    logic [ADDR_BITS-1:0] reg_idx;
    logic                 wr_en;
    logic [DATA_BITS-1:0] wr_data, rd_data;
    fsm_e                 fsm_state;

    mgmt_mdc_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mgmt_frame_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .fall    (fall),
        .mdio_in (mdio_in),
        .phy_addr(phy_addr),
        .rd_data (rd_data),
        .reg_idx (reg_idx),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mdio_out(mdio_out),
        .mdio_oe (mdio_oe),
        .state   (fsm_state)
    );

    mgmt_reg_bank #(
        .NUM_REGS  (NUM_REGS),
        .STATUS_VAL(STATUS_VAL),
        .ID_HI     (ID_HI),
        .ID_LO     (ID_LO)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (reg_idx),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/mgmt_serial_slave_chk.sv
module mgmt_serial_slave_chk
    import mgmt_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdio_out,
    input logic mdio_oe,
    input fsm_e fsm_state,
    input logic wr_en
);
    AST_OE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> fsm_state == ST_DATA); // R6

    AST_OE_DROP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> fsm_state == ST_IDLE); // R6

    AST_OE_RISE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdc); // R5

    AST_OUT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mdc) |-> $stable(mdio_out)); // R5

    AST_WRITE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> fsm_state == ST_DATA); // R7

    AST_WRITE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> fsm_state == ST_IDLE); // R2

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !mdio_oe && !mdio_out); // R10
endmodule

bind mgmt_serial_slave mgmt_serial_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .fsm_state(fsm_state),
    .wr_en    (wr_en)
);

// File: tb/tb_mgmt_serial_slave.sv
`timescale 1ns/1ps
module tb_mgmt_serial_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mdc = 1'b0;
    logic       m_drv = 1'b1;
    logic [4:0] phy_addr = 5'd5;
    logic       mdio_out, mdio_oe;
    wire        mdio_in = mdio_oe ? mdio_out : m_drv;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [15:0] model [8];

    always #2.5 clk = ~clk;

    mgmt_serial_slave dut (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
        .phy_addr(phy_addr), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    function automatic logic [15:0] exp_mask(int i);
        case (i)
            1, 2, 3: return 16'hFFFF;
            4:       return 16'h001F;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] exp_reset(int i);
        case (i)
            0: return 16'h1140;
            1: return 16'h7949;
            2: return 16'h0141;
            3: return 16'h0CC2;
            4: return 16'h01E1;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        m_drv = b; mdc = 1'b0; half();
        mdc = 1'b1; half();
    endtask

    // one frame; returns read bits and output-enable observations
    task automatic frame(int pre_ones, logic [1:0] op, logic [4:0] dev,
                         logic [4:0] idx, logic [15:0] wd,
                         output logic [15:0] rd, output int oe_cnt,
                         output int oe_outside);
        oe_cnt = 0; oe_outside = 0; rd = '0;
        for (int i = 0; i < pre_ones; i++) send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 4; i >= 0; i--) send_bit(dev[i]);
        for (int i = 4; i >= 0; i--) send_bit(idx[i]);
        send_bit(1'b1); send_bit(op == 2'b01 ? 1'b0 : 1'b1);
        if (mdio_oe) oe_outside++;
        for (int i = 15; i >= 0; i--) begin
            m_drv = wd[i]; mdc = 1'b0; half();
            rd[i] = mdio_out;
            if (mdio_oe) oe_cnt++;
            mdc = 1'b1; half();
        end
        if (mdio_oe) oe_outside++;
        m_drv = 1'b1;
    endtask

    task automatic do_read(logic [4:0] dev, logic [4:0] idx,
                           output logic [15:0] rd, output int oe_cnt,
                           output int oe_out);
        frame(32, 2'b10, dev, idx, 16'h0000, rd, oe_cnt, oe_out);
    endtask

    task automatic do_write(logic [1:0] op, logic [4:0] dev, logic [4:0] idx,
                            logic [15:0] wd);
        logic [15:0] rd; int a, b;
        frame(32, op, dev, idx, wd, rd, a, b);
    endtask

    function automatic logic [15:0] exp_reg(int i);
        return (i < 8) ? model[i] : 16'h0000;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int oc, oo;
        logic [15:0] pats [3];
        pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'hA5C3;
        for (int i = 0; i < 8; i++) model[i] = exp_reset(i);

        repeat (3) @(negedge clk);
        check("R10 oe in reset", mdio_oe, 1'b0);
        check("R10 out in reset", mdio_out, 1'b0);
        rst_n = 1'b1;
        half();
        check("R10 oe after reset", mdio_oe, 1'b0);
        check("R10 out after reset", mdio_out, 1'b0);

        // R8 R9 R2 R5: read every index
        for (int i = 0; i < 32; i++) begin
            do_read(5'd5, 5'(i), rd, oc, oo);
            check($sformatf("R8/R9/R2/R5 read idx %0d", i), rd, exp_reg(i));
            check($sformatf("R6 oe during read idx %0d", i), oc, 16);
            check($sformatf("R6 oe outside data idx %0d", i), oo, 0);
        end

        // R7: masked writes
        foreach (pats[p]) begin
            for (int i = 0; i < 8; i++) begin
                do_write(2'b01, 5'd5, 5'(i), pats[p] ^ 16'(i));
                model[i] = (model[i] & exp_mask(i)) | ((pats[p] ^ 16'(i)) & ~exp_mask(i));
                do_read(5'd5, 5'(i), rd, oc, oo);
                check($sformatf("R7 write idx %0d pat %0d", i, p), rd, model[i]);
            end
        end

        // R9: write past the bank is dropped
        do_write(2'b01, 5'd5, 5'd9, 16'h5A5A);
        do_read(5'd5, 5'd9, rd, oc, oo);
        check("R9 write beyond bank", rd, 16'h0000);
        do_read(5'd5, 5'd1, rd, oc, oo);
        check("R9 no alias into idx 1", rd, model[1]);

        // R4: non-matching device
        do_write(2'b01, 5'd6, 5'd0, 16'hBEEF);
        do_read(5'd5, 5'd0, rd, oc, oo);
        check("R4 foreign write ignored", rd, model[0]);
        do_read(5'd6, 5'd0, rd, oc, oo);
        check("R4 foreign read no drive", oc + oo, 0);

        // R3: unused access codes
        do_write(2'b00, 5'd5, 5'd0, 16'h0F0F);
        do_read(5'd5, 5'd0, rd, oc, oo);
        check("R3 code 00 no write", rd, model[0]);
        frame(32, 2'b11, 5'd5, 5'd0, 16'hF0F0, rd, oc, oo);
        check("R3 code 11 no drive", oc + oo, 0);
        do_read(5'd5, 5'd0, rd, oc, oo);
        check("R3 code 11 no write", rd, model[0]);

        // R1: truncated preamble
        frame(20, 2'b01, 5'd5, 5'd0, 16'h1234, rd, oc, oo);
        do_read(5'd5, 5'd0, rd, oc, oo);
        check("R1 short preamble ignored", rd, model[0]);
        frame(30, 2'b01, 5'd5, 5'd5, 16'h3C3C, rd, oc, oo);
        model[5] = 16'h3C3C;
        do_read(5'd5, 5'd5, rd, oc, oo);
        check("R1 minimum preamble accepted", rd, model[5]);

        // R4: every device address against a new configured address
        phy_addr = 5'd17;
        for (int a = 0; a < 32; a++) begin
            do_read(5'(a), 5'd2, rd, oc, oo);
            check($sformatf("R4 oe for dev %0d", a), oc, (a == 17) ? 16 : 0);
            if (a == 17) check("R4 matched read id", rd, 16'h0141);
        end

        half();
        check("R6 oe idle at end", mdio_oe, 1'b0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule